// File: doc/BRIEF.md
# Page-Write Loader with Inactivity Timer

This block sits behind an asynchronous, SRAM-style write bus (active-low chip enable, write enable and output enable, a 15-bit address and an 8-bit data bus). It samples the bus with a synchronous clock and turns each complete bus write into one write on a page-buffer port. The six low address bits pick the buffer entry, and the nine high bits name the page. For each entry it keeps a flag that records that the entry holds a loaded byte.

The first byte write opens a load session. Every later byte must end within a load window that runs from the end of the previous byte. When the window passes with no new write, the block issues a single-cycle program-start pulse with the page number and the set of valid entries. It then reports busy for a fixed programming time and clears all valid flags at the end. If any byte in the session names a page other than the first byte's page, the session is dropped: no programming starts and the flags are cleared. Writes that arrive while programming runs are ignored. Both windows are parameters in clock cycles.

Top module: `pgload_top`

## Requirements
- R1: A bus write counts only while chip enable and write enable are both low and output enable is high. A strobe pattern with output enable low, or with chip enable high, produces no buffer write.
- R2: The buffer index is bits 5..0 of the address present in the first sampled cycle in which the write condition holds. Address changes later in the same write have no effect.
- R3: The buffer data is the data present in the last sampled cycle in which the write condition holds, whichever strobe is released first.
- R4: Each accepted bus write gives exactly one single-cycle buffer write (`buf_we`) with its index and data.
- R5: At the program-start pulse, `prog_mask` has bit i set exactly for each entry i written during the session.
- R6: `prog_page` at the program-start pulse equals bits 14..6 of the session's first byte.
- R7: `prog_start` is a one-cycle pulse that rises exactly LOAD_CYC+1 clock cycles after the cycle of the session's last buffer write.
- R8: A new byte that starts before the load window has run out restarts the window, and its entry joins the same session.
- R9: If any byte of a session has bits 14..6 that differ from the first byte's, no `prog_start` occurs, `busy` stays low and all valid flags are clear once the window expires.
- R10: `busy` goes high in the same cycle as `prog_start` and stays high for exactly PROG_CYC cycles.
- R11: A bus write that starts while `busy` is high produces no buffer write and does not open a new session.
- R12: In the first cycle after `busy` falls, `prog_mask` is all zero.
- R13: After reset, `buf_we`, `prog_start`, `busy` and `prog_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (15) | Byte address: entry in low bits, page in high bits |
| din | input | DATA_W (8) | Write data |
| buf_we | output | 1 | Page-buffer write strobe, one cycle per byte |
| buf_idx | output | IDX_W (6) | Page-buffer entry being written |
| buf_data | output | DATA_W (8) | Byte being written to the buffer |
| prog_start | output | 1 | One-cycle pulse that starts programming |
| prog_page | output | PAGE_W (9) | Page number for the programming cycle |
| prog_mask | output | PAGE_BYTES (64) | Valid flag for each buffer entry |
| busy | output | 1 | High while the programming time runs |

## Verification
The assertions assume that the strobes, address and data are stable enough for the sampling clock to see every write condition for at least one cycle, and that a write is never held active long enough to span a whole session. The stimulus changes the bus only at the falling clock edge. It holds each write condition for three cycles and releases both strobes within two cycles. The address and data carry deliberately wrong values outside the cycles where R2 and R3 say they are taken, so any capture in the wrong cycle shows up.

// File: rtl/pgl_pkg.sv
package pgl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pgl_state_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/pgl_sampler.sv
module pgl_sampler #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] pipe_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
            end else begin
               pipe_q[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign q = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pgl_capture.sv
module pgl_capture #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] din_s,
   input  logic              busy,
   output logic              wr_evt,
   output logic              act_o,
   output logic [ADDR_W-1:0] addr_cap,
   output logic [DATA_W-1:0] data_cap
);

   logic act_d;
   logic armed_q;
   logic st_evt;
   logic end_evt;

   assign st_evt  = act_s & ~act_d;
   assign end_evt = act_d & ~act_s;
   assign wr_evt  = end_evt & armed_q;
   assign act_o   = act_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d    <= 1'b0;
         armed_q  <= 1'b0;
         addr_cap <= '0;
         data_cap <= '0;
      end else begin
         act_d <= act_s;
         if (st_evt) begin
            addr_cap <= addr_s;
            armed_q  <= ~busy;
         end else if (end_evt) begin
            armed_q  <= 1'b0;
         end
         if (act_s) data_cap <= din_s;
      end
   end

   // R4
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> !wr_evt);

endmodule

// File: rtl/pgl_valid.sv
module pgl_valid #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic               clr,
   output logic [ENTRIES-1:0] valid
);

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               valid[g] <= 1'b0;
            else if (clr)                             valid[g] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(g))  valid[g] <= 1'b1;
         end
      end
   endgenerate

   // R12
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (valid == '0));

endmodule

// File: rtl/pgl_ctrl.sv
module pgl_ctrl
   import pgl_pkg::*;
#(
   parameter int unsigned PAGE_W   = 9,
   parameter int unsigned LOAD_CYC = 150,
   parameter int unsigned PROG_CYC = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_evt,
   input  logic              act,
   input  logic [PAGE_W-1:0] wr_page,
   output logic              prog_start,
   output logic [PAGE_W-1:0] prog_page,
   output logic              busy,
   output logic              clr
);

   localparam int unsigned LW = cnt_width(LOAD_CYC);
   localparam int unsigned PW = cnt_width(PROG_CYC);
   localparam logic [LW-1:0] LOAD_LAST = LW'(LOAD_CYC - 1);
   localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);

   pgl_state_e        state_q;
   logic [LW-1:0]     lcnt_q;
   logic [PW-1:0]     pcnt_q;
   logic [PAGE_W-1:0] first_q;
   logic              rej_q;
   logic              load_exp;

   assign load_exp = (state_q == ST_LOAD) && !wr_evt && !act && (lcnt_q == LOAD_LAST);
   assign busy     = (state_q == ST_PROG);
   assign clr      = (load_exp && rej_q) ||
                     ((state_q == ST_PROG) && (pcnt_q == PROG_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         lcnt_q     <= '0;
         pcnt_q     <= '0;
         first_q    <= '0;
         rej_q      <= 1'b0;
         prog_start <= 1'b0;
         prog_page  <= '0;
      end else begin
         prog_start <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (wr_evt) begin
                  first_q <= wr_page;
                  rej_q   <= 1'b0;
                  lcnt_q  <= '0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (wr_evt) begin
                  lcnt_q <= '0;
                  if (wr_page != first_q) rej_q <= 1'b1;
               end else if (act) begin
                  lcnt_q <= '0;
               end else if (load_exp) begin
                  if (rej_q) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q    <= ST_PROG;
                     pcnt_q     <= '0;
                     prog_start <= 1'b1;
                     prog_page  <= first_q;
                  end
               end else begin
                  lcnt_q <= lcnt_q + 1'b1;
               end
            end
            ST_PROG: begin
               if (pcnt_q == PROG_LAST) state_q <= ST_IDLE;
               else                     pcnt_q  <= pcnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R10
   busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> prog_start);

   // R7
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);

   // R11
   no_session_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_evt);

endmodule

// File: rtl/pgload_top.sv
module pgload_top
   import pgl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PAGE_BYTES  = 64,
   parameter int unsigned LOAD_CYC    = 150,
   parameter int unsigned PROG_CYC    = 5000,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = $clog2(PAGE_BYTES),
   localparam int unsigned PAGE_W     = ADDR_W - IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ce_n,
   input  logic                  we_n,
   input  logic                  oe_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     din,
   output logic                  buf_we,
   output logic [IDX_W-1:0]      buf_idx,
   output logic [DATA_W-1:0]     buf_data,
   output logic                  prog_start,
   output logic [PAGE_W-1:0]     prog_page,
   output logic [PAGE_BYTES-1:0] prog_mask,
   output logic                  busy
);

   localparam int unsigned SW = 1 + ADDR_W + DATA_W;

   generate
      if (PAGE_BYTES != (1 << IDX_W)) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the entry index width");
      end
      if (LOAD_CYC < 2 || PROG_CYC < 2) begin : g_bad_cyc
         $error("LOAD_CYC and PROG_CYC must be at least 2");
      end
   endgenerate

   logic              act_raw;
   logic [SW-1:0]     smp_d, smp_q;
   logic              act_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;
   logic              wr_evt;
   logic              act_c;
   logic [ADDR_W-1:0] addr_cap;
   logic [DATA_W-1:0] data_cap;
   logic              clr;

   assign act_raw = ~ce_n & ~we_n & oe_n;
   assign smp_d   = {act_raw, addr, din};
   assign {act_s, addr_s, din_s} = smp_q;

   pgl_sampler #(.W(SW), .STAGES(SYNC_STAGES)) sampler_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (smp_d),
      .q     (smp_q)
   );

   pgl_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) capture_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_s    (act_s),
      .addr_s   (addr_s),
      .din_s    (din_s),
      .busy     (busy),
      .wr_evt   (wr_evt),
      .act_o    (act_c),
      .addr_cap (addr_cap),
      .data_cap (data_cap)
   );

   assign buf_we   = wr_evt;
   assign buf_idx  = addr_cap[IDX_W-1:0];
   assign buf_data = data_cap;

   pgl_ctrl #(.PAGE_W(PAGE_W), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_evt     (wr_evt),
      .act        (act_c),
      .wr_page    (addr_cap[ADDR_W-1:IDX_W]),
      .prog_start (prog_start),
      .prog_page  (prog_page),
      .busy       (busy),
      .clr        (clr)
   );

   pgl_valid #(.ENTRIES(PAGE_BYTES), .IDX_W(IDX_W)) valid_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (wr_evt),
      .set_idx (addr_cap[IDX_W-1:0]),
      .clr     (clr),
      .valid   (prog_mask)
   );

   // R11
   no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !buf_we);

   // R12
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (prog_mask == '0));

   // R5
   mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (prog_mask != '0));

   // R4
   mask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |=> prog_mask[$past(buf_idx)]);

endmodule

// File: tb/pgload_top_tb_top.sv
module pgload_top_tb_top;

   localparam int LOAD = 20;
   localparam int PROG = 60;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [14:0] addr = '0;
   logic [7:0]  din = '0;
   logic        buf_we, prog_start, busy;
   logic [5:0]  buf_idx;
   logic [7:0]  buf_data;
   logic [8:0]  prog_page;
   logic [63:0] prog_mask;

   int errors = 0, checks = 0;
   int cyc = 0, nwe = 0, nstart = 0, busy_cnt = 0;
   int we_cyc = 0, st_cyc = 0;
   logic [5:0]  last_idx = '0;
   logic [7:0]  last_data = '0;
   logic [8:0]  st_page = '0;
   logic [63:0] st_mask = '0;

   always #10 clk = ~clk;

   pgload_top #(.LOAD_CYC(LOAD), .PROG_CYC(PROG), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .buf_we(buf_we), .buf_idx(buf_idx),
      .buf_data(buf_data), .prog_start(prog_start), .prog_page(prog_page),
      .prog_mask(prog_mask), .busy(busy)
   );

   always @(negedge clk) begin
      cyc++;
      if (buf_we) begin
         nwe++; we_cyc = cyc; last_idx = buf_idx; last_data = buf_data;
      end
      if (prog_start) begin
         nstart++; st_cyc = cyc; st_page = prog_page; st_mask = prog_mask;
      end
      if (busy) busy_cnt++;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // bus write; ce_last selects chip-enable-controlled ordering
   task automatic wr(input logic [14:0] a, input logic [7:0] d,
                     input bit ce_last, input logic oe);
      @(negedge clk);
      addr = ~a; din = ~d;
      if (ce_last) begin we_n = 1'b0; ce_n = 1'b1; end
      else         begin ce_n = 1'b0; we_n = 1'b1; end
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = a;
      @(negedge clk);
      addr = a ^ 15'h002A;
      @(negedge clk);
      din = d;
      @(negedge clk);
      din = ~d; addr = ~a;
      if (ce_last) ce_n = 1'b1; else we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (SYNC + 3) @(negedge clk);
   endtask

   task automatic wr_chk(input logic [14:0] a, input logic [7:0] d, input bit ce_last);
      int n0;
      n0 = nwe;
      wr(a, d, ce_last, 1'b1);
      chk(nwe == n0 + 1, "R4", nwe - n0, 1);
      chk(last_idx == a[5:0], "R2", last_idx, a[5:0]);
      chk(last_data == d, "R3", last_data, d);
   endtask

   task automatic wait_start_or(input int lim);
      int s0;
      s0 = nstart;
      for (int i = 0; i < lim && nstart == s0; i++) @(negedge clk);
   endtask

   task automatic check_program(input logic [8:0] pg, input logic [63:0] mask);
      int s0, b0;
      s0 = nstart;
      b0 = busy_cnt;
      wait_start_or(LOAD + 10);
      chk(nstart == s0 + 1, "R7", nstart - s0, 1);
      chk(st_cyc - we_cyc == LOAD + 1, "R7", st_cyc - we_cyc, LOAD + 1);
      chk(st_page == pg, "R6", st_page, pg);
      chk(st_mask == mask, "R5", st_mask, mask);
      for (int i = 0; i < PROG + 10 && busy; i++) @(negedge clk);
      @(negedge clk);
      chk(busy_cnt - b0 == PROG, "R10", busy_cnt - b0, PROG);
      chk(prog_mask == 64'd0, "R12", prog_mask, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      int n0, s0;
      logic [63:0] m;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk({buf_we, prog_start, busy} == 3'b000, "R13", {buf_we, prog_start, busy}, 0);
      chk(prog_mask == 64'd0, "R13", prog_mask, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: output enable low, and chip enable held high, are not writes
      n0 = nwe; s0 = nstart;
      wr(15'h0145, 8'h5A, 1'b0, 1'b0);
      @(negedge clk); we_n = 1'b0; oe_n = 1'b1; addr = 15'h0146;
      repeat (4) @(negedge clk); we_n = 1'b1;
      repeat (LOAD + 10) @(negedge clk);
      chk(nwe == n0, "R1", nwe - n0, 0);
      chk(nstart == s0 && !busy, "R1", nstart - s0, 0);

      // full-page sweep, page 5, alternating strobe order
      for (int i = 0; i < 64; i++)
         wr_chk({9'd5, 6'(i)}, 8'((i * 7 + 3) & 255), i[0]);
      check_program(9'd5, {64{1'b1}});

      // R8: scattered entries, gaps near the window
      wr_chk({9'h155, 6'd3}, 8'hC3, 1'b1);
      repeat (LOAD - 12) @(negedge clk);
      wr_chk({9'h155, 6'd60}, 8'h3C, 1'b0);
      repeat (LOAD - 12) @(negedge clk);
      wr_chk({9'h155, 6'd17}, 8'h11, 1'b1);
      m = '0; m[3] = 1'b1; m[60] = 1'b1; m[17] = 1'b1;
      check_program(9'h155, m);

      // R9: mixed pages are rejected
      s0 = nstart;
      wr_chk({9'd2, 6'd1}, 8'hA1, 1'b0);
      wr_chk({9'd3, 6'd2}, 8'hA2, 1'b0);
      repeat (LOAD + 10) @(negedge clk);
      chk(nstart == s0, "R9", nstart - s0, 0);
      chk(!busy, "R9", busy, 0);
      chk(prog_mask == 64'd0, "R9", prog_mask, 0);

      // R11: write during programming is ignored
      wr_chk({9'h1FF, 6'd63}, 8'hEE, 1'b0);
      wait_start_or(LOAD + 10);
      s0 = nstart;
      n0 = nwe;
      wr(15'h0007, 8'h77, 1'b0, 1'b1);
      chk(nwe == n0, "R11", nwe - n0, 0);
      m = '0; m[63] = 1'b1;
      chk(prog_mask == m, "R11", prog_mask, m);
      for (int i = 0; i < PROG + 10 && busy; i++) @(negedge clk);
      repeat (LOAD + 10) @(negedge clk);
      chk(nstart == s0, "R11", nstart - s0, 0);
      chk(prog_mask == 64'd0, "R12", prog_mask, 0);

      summary();
   end

endmodule